// File: doc/BRIEF.md
# Write-Through Data Cache Controller with Line Invalidation

This block is the control engine of a small direct-mapped, write-through data cache. A CPU side presents loads and stores over a valid/ready request channel. A separate requester names a cache line by index and asks for it to be invalidated. Inside the block sit a valid/tag array and a byte-laned data array. Two handshake ports stand in for the memory system: one carries write-through stores out, and the other fetches a word on a load miss. Each line holds one word. Stores never allocate a line: a store hit updates the cached word under its byte enables, and every store is also written through to memory.

The block has four states: idle, read, write and invalidate. A request and an invalidate can arrive in the same idle cycle. In that case both are taken. The request is held in a pending register and the invalidation runs first, alone, for one cycle. The controller then goes straight from invalidate to the pending read or write. It does not pass through idle, so no later invalidate can get in ahead of the held request. The held request runs from the pending register, so the CPU may drop its valid as soon as the request is accepted. The invalidate acknowledge pulses only after the valid bit has been cleared.

Back-pressure rules are as follows. The request channel transfers in a cycle where `cpu_req_valid` and `cpu_req_ready` are both high, and ready is high only in idle. The response pulse has no ready and must be taken in the cycle it appears. On the write-through and refill ports the block holds valid and payload steady until the memory side raises ready. The invalidate requester holds `inv_req` and `inv_line` until it sees `inv_ack`, then releases them.

Top module: `dcache_inv_ctrl`

## Requirements
- R1: After reset the controller is idle with `cpu_req_ready` high, `inv_ack`, `mem_wr_valid`, `refill_valid` and `cpu_rsp_valid` low, and every line invalid, so the first load to any address misses.
- R2: `cpu_req_ready` is high exactly in idle. A request transfers when valid and ready are both high, and its opcode, address, data and byte enables are captured at that edge.
- R3: A load that hits gives `cpu_rsp_valid` with the stored word on `cpu_rsp_rdata` in the cycle after acceptance, and raises no refill.
- R4: A load that misses raises `refill_valid` with the word-aligned address (low two bits zero), holding both until `refill_ready`. In that handshake cycle the response carries `refill_data`, and the line becomes valid with that word and the load's tag.
- R5: A store drives `mem_wr_valid` with its address, data and byte enables, held until `mem_wr_ready`. The response has `cpu_rsp_write` high in that handshake cycle. On a hit, enable bit b replaces byte b (bits 8b+7..8b) of the cached word. A miss leaves the array unchanged.
- R6: An invalidate accepted in idle spends one cycle clearing the valid bit of line `inv_line`. `inv_ack` is high for exactly the next cycle. An `inv_req` still high during that ack cycle does not start a second invalidation.
- R7: When a request and an invalidate are accepted in the same idle cycle, the invalidation runs first. The request follows directly after it with no idle cycle in between, and it sees the array after the invalidation: a store or load to the invalidated line misses.
- R8: An accepted request completes even if `cpu_req_valid` drops right after acceptance and the memory side stalls for many cycles.
- R9: An invalidate raised while a request is in progress is not performed and not acknowledged until the controller is back in idle.
- R10: Each accepted request produces exactly one single-cycle `cpu_rsp_valid` pulse, and the bit `cpu_rsp_write` tells stores from loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | CPU request present |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_we | input | 1 | 1 for store, 0 for load |
| cpu_req_addr | input | AW | Byte address |
| cpu_req_wdata | input | DW | Store data |
| cpu_req_be | input | DW/8 | Store byte enables |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_write | output | 1 | Completion belongs to a store |
| cpu_rsp_rdata | output | DW | Load data, zero for stores |
| inv_req | input | 1 | Line invalidate request, held until ack |
| inv_line | input | log2(LINES) | Index of line to invalidate |
| inv_ack | output | 1 | Invalidation done |
| mem_wr_valid | output | 1 | Write-through store present |
| mem_wr_ready | input | 1 | Memory accepts the store |
| mem_wr_addr | output | AW | Store address |
| mem_wr_data | output | DW | Store data |
| mem_wr_be | output | DW/8 | Store byte enables |
| refill_valid | output | 1 | Miss fetch request |
| refill_ready | input | 1 | Fetch data returned |
| refill_addr | output | AW | Word-aligned fetch address |
| refill_data | input | DW | Fetched word |

## Verification
The hardest case to reach is an invalidate and a store landing in the same idle cycle on the same line, followed by a write-through stall while the CPU has already withdrawn its request. Random traffic alone rarely lines this up. The stimulus therefore first steers it directly: it primes a line, raises both requests together with memory ready held low, and then reads the line back to show it misses. After that, long random traffic confined to eight addresses over four lines makes such collisions recur under random ready patterns, with a behavioural model compared on every clock.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_INVAL = 2'd3
  } dcc_state_e;
endpackage

// File: rtl/dcc_tag_array.sv
module dcc_tag_array #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [LINES];

  // clear and fill are never issued in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (clr_en)  vld_q[clr_idx]  <= 1'b0;
      if (fill_en) vld_q[fill_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx] <= fill_tag;
  end

  assign lk_hit = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
endmodule

// File: rtl/dcc_data_array.sv
module dcc_data_array #(
  parameter int IDX_W = 4,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DW-1:0]     rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DW/8-1:0]   wr_be,
  input  logic [DW-1:0]     wr_data
);
  localparam int LINES = 1 << IDX_W;
  localparam int NLANE = DW / 8;

  for (genvar b = 0; b < NLANE; b++) begin : g_lane
    logic [7:0] lane_q [LINES];
    always_ff @(posedge clk) begin
      if (wr_en && wr_be[b]) lane_q[wr_idx] <= wr_data[8*b +: 8];
    end
    assign rd_data[8*b +: 8] = lane_q[rd_idx];
  end
endmodule

// File: rtl/dcc_ctrl.sv
module dcc_ctrl
  import dcc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [DW/8-1:0]   req_be,
  output logic              rsp_valid,
  output logic              rsp_write,
  output logic [DW-1:0]     rsp_rdata,
  input  logic              inv_req,
  input  logic [IDX_W-1:0]  inv_line,
  output logic              inv_ack,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [AW-1:0]     mem_wr_addr,
  output logic [DW-1:0]     mem_wr_data,
  output logic [DW/8-1:0]   mem_wr_be,
  output logic              refill_valid,
  input  logic              refill_ready,
  output logic [AW-1:0]     refill_addr,
  input  logic [DW-1:0]     refill_data,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [AW-IDX_W-$clog2(DW/8)-1:0] lk_tag,
  input  logic              lk_hit,
  output logic              clr_en,
  output logic [IDX_W-1:0]  clr_idx,
  output logic              fill_en,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [AW-IDX_W-$clog2(DW/8)-1:0] fill_tag,
  output logic              dw_en,
  output logic [IDX_W-1:0]  dw_idx,
  output logic [DW/8-1:0]   dw_be,
  output logic [DW-1:0]     dw_data,
  input  logic [DW-1:0]     dr_data
);
  localparam int BE_W  = DW / 8;
  localparam int OFF_W = $clog2(BE_W);
  localparam int TAG_W = AW - IDX_W - OFF_W;

  dcc_state_e        state_q, state_d;
  logic              pend_q;
  logic              pwe_q;
  logic [AW-1:0]     pa_q;
  logic [DW-1:0]     pd_q;
  logic [BE_W-1:0]   pbe_q;
  logic              ack_q;
  logic [IDX_W-1:0]  ia_q;

  logic idle, take, inv_go, in_rd, in_wr, rd_done, wr_done;

  assign idle    = (state_q == ST_IDLE);
  assign in_rd   = (state_q == ST_READ);
  assign in_wr   = (state_q == ST_WRITE);
  assign take    = idle && req_valid;
  // an invalidate is new only when it is not the one just acknowledged
  assign inv_go  = idle && inv_req && !ack_q;

  assign lk_idx  = pa_q[OFF_W +: IDX_W];
  assign lk_tag  = pa_q[AW-1 -: TAG_W];

  assign rd_done = in_rd && (lk_hit || refill_ready);
  assign wr_done = in_wr && mem_wr_ready;

  assign req_ready    = idle;
  assign rsp_valid    = rd_done || wr_done;
  assign rsp_write    = in_wr;
  assign rsp_rdata    = !in_rd ? '0 : (lk_hit ? dr_data : refill_data);
  assign inv_ack      = ack_q;

  assign mem_wr_valid = in_wr;
  assign mem_wr_addr  = pa_q;
  assign mem_wr_data  = pd_q;
  assign mem_wr_be    = pbe_q;

  assign refill_valid = in_rd && !lk_hit;
  assign refill_addr  = {pa_q[AW-1:OFF_W], {OFF_W{1'b0}}};

  assign clr_en   = (state_q == ST_INVAL);
  assign clr_idx  = ia_q;
  assign fill_en  = in_rd && !lk_hit && refill_ready;
  assign fill_idx = lk_idx;
  assign fill_tag = lk_tag;

  assign dw_en   = fill_en || (wr_done && lk_hit);
  assign dw_idx  = lk_idx;
  assign dw_be   = fill_en ? {BE_W{1'b1}} : pbe_q;
  assign dw_data = fill_en ? refill_data : pd_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (inv_go)    state_d = ST_INVAL;
        else if (take) state_d = req_we ? ST_WRITE : ST_READ;
      end
      // held request goes first, straight from the invalidation
      ST_INVAL: begin
        if (pend_q) state_d = pwe_q ? ST_WRITE : ST_READ;
        else        state_d = ST_IDLE;
      end
      ST_READ:  if (rd_done) state_d = ST_IDLE;
      ST_WRITE: if (wr_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= (state_q == ST_INVAL);
      if (take)           pend_q <= 1'b1;
      else if (rsp_valid) pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwe_q <= 1'b0;
      pa_q  <= '0;
      pd_q  <= '0;
      pbe_q <= '0;
      ia_q  <= '0;
    end else begin
      if (take) begin
        pwe_q <= req_we;
        pa_q  <= req_addr;
        pd_q  <= req_wdata;
        pbe_q <= req_be;
      end
      if (inv_go) ia_q <= inv_line;
    end
  end
endmodule

// File: rtl/dcache_inv_ctrl.sv
module dcache_inv_ctrl #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LINES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_req_valid,
  output logic                     cpu_req_ready,
  input  logic                     cpu_req_we,
  input  logic [AW-1:0]            cpu_req_addr,
  input  logic [DW-1:0]            cpu_req_wdata,
  input  logic [DW/8-1:0]          cpu_req_be,
  output logic                     cpu_rsp_valid,
  output logic                     cpu_rsp_write,
  output logic [DW-1:0]            cpu_rsp_rdata,
  input  logic                     inv_req,
  input  logic [$clog2(LINES)-1:0] inv_line,
  output logic                     inv_ack,
  output logic                     mem_wr_valid,
  input  logic                     mem_wr_ready,
  output logic [AW-1:0]            mem_wr_addr,
  output logic [DW-1:0]            mem_wr_data,
  output logic [DW/8-1:0]          mem_wr_be,
  output logic                     refill_valid,
  input  logic                     refill_ready,
  output logic [AW-1:0]            refill_addr,
  input  logic [DW-1:0]            refill_data
);
  localparam int BE_W  = DW / 8;
  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(BE_W);
  localparam int TAG_W = AW - IDX_W - OFF_W;

  logic [IDX_W-1:0] lk_idx, clr_idx, fill_idx, dw_idx;
  logic [TAG_W-1:0] lk_tag, fill_tag;
  logic             lk_hit, clr_en, fill_en, dw_en;
  logic [BE_W-1:0]  dw_be;
  logic [DW-1:0]    dw_data, dr_data;

  dcc_ctrl #(.AW(AW), .DW(DW), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(cpu_req_valid), .req_ready(cpu_req_ready), .req_we(cpu_req_we),
    .req_addr(cpu_req_addr), .req_wdata(cpu_req_wdata), .req_be(cpu_req_be),
    .rsp_valid(cpu_rsp_valid), .rsp_write(cpu_rsp_write), .rsp_rdata(cpu_rsp_rdata),
    .inv_req(inv_req), .inv_line(inv_line), .inv_ack(inv_ack),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be),
    .refill_valid(refill_valid), .refill_ready(refill_ready), .refill_addr(refill_addr),
    .refill_data(refill_data),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit),
    .clr_en(clr_en), .clr_idx(clr_idx),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag),
    .dw_en(dw_en), .dw_idx(dw_idx), .dw_be(dw_be), .dw_data(dw_data), .dr_data(dr_data)
  );

  dcc_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit),
    .clr_en(clr_en), .clr_idx(clr_idx),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag)
  );

  dcc_data_array #(.IDX_W(IDX_W), .DW(DW)) u_data (
    .clk(clk),
    .rd_idx(lk_idx), .rd_data(dr_data),
    .wr_en(dw_en), .wr_idx(dw_idx), .wr_be(dw_be), .wr_data(dw_data)
  );
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req_valid,
  input logic          cpu_req_ready,
  input logic          inv_req,
  input logic          inv_ack,
  input logic          mem_wr_valid,
  input logic          mem_wr_ready,
  input logic [AW-1:0] mem_wr_addr,
  input logic [DW-1:0] mem_wr_data,
  input logic          refill_valid,
  input logic          refill_ready,
  input logic [AW-1:0] refill_addr,
  input logic          clr_en,
  input logic          fill_en,
  input logic          dw_en
);
  // R6: acknowledge only after the clear was issued
  p_ack_after_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inv_ack |-> $past(clr_en));

  // R6: every clear is acknowledged next cycle
  p_clear_acked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> inv_ack);

  // R5: write-through payload held while stalled
  p_wr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  // R4: refill request held while stalled
  p_rf_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_valid && !refill_ready) |=> (refill_valid && $stable(refill_addr)));

  // R2: no new request taken while a memory transfer is open
  p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid || refill_valid) |-> !cpu_req_ready);

  // R7: a collision performs the invalidation first
  p_col_inv_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_ready && inv_req && !inv_ack) |=> (clr_en && !cpu_req_ready));

  // R7: no idle cycle between the clear and the held request
  p_col_no_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && $past(cpu_req_valid && cpu_req_ready)) |=> !cpu_req_ready);

  // R5: a store changes the data array only while its write-through completes
  p_store_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dw_en && !fill_en) |-> (mem_wr_valid && mem_wr_ready));
endmodule

bind dcache_inv_ctrl dcc_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
  .inv_req(inv_req), .inv_ack(inv_ack),
  .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
  .refill_valid(refill_valid), .refill_ready(refill_ready), .refill_addr(refill_addr),
  .clr_en(clr_en), .fill_en(fill_en), .dw_en(dw_en)
);

// File: tb/sim_dcache_inv_ctrl.sv
`timescale 1ns/1ps
module sim_dcache_inv_ctrl;
  localparam int AW = 32, DW = 32, LINES = 16;
  localparam int IDX_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_v = 0, req_we = 0;
  logic [31:0]   req_a = 0, req_d = 0;
  logic [3:0]    req_be = 0;
  logic          inv_r = 0;
  logic [3:0]    inv_a = 0;
  logic          mw_rdy = 1, rf_rdy = 1;

  logic          cpu_req_ready, cpu_rsp_valid, cpu_rsp_write, inv_ack;
  logic [31:0]   cpu_rsp_rdata, mem_wr_addr, mem_wr_data, refill_addr, refill_data;
  logic [3:0]    mem_wr_be;
  logic          mem_wr_valid, refill_valid;

  function automatic logic [31:0] fetch_word(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction
  assign refill_data = fetch_word(refill_addr);

  dcache_inv_ctrl #(.AW(AW), .DW(DW), .LINES(LINES)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(req_v), .cpu_req_ready(cpu_req_ready), .cpu_req_we(req_we),
    .cpu_req_addr(req_a), .cpu_req_wdata(req_d), .cpu_req_be(req_be),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_write(cpu_rsp_write), .cpu_rsp_rdata(cpu_rsp_rdata),
    .inv_req(inv_r), .inv_line(inv_a), .inv_ack(inv_ack),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mw_rdy), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be),
    .refill_valid(refill_valid), .refill_ready(rf_rdy), .refill_addr(refill_addr),
    .refill_data(refill_data)
  );

  // reference model: 0 idle, 1 load, 2 store, 3 invalidate
  int          m_ph;
  bit          m_pv, m_pwe, m_ack;
  logic [31:0] m_pa, m_pd;
  logic [3:0]  m_pbe;
  int          m_ia;
  bit          mv [LINES];
  logic [25:0] mt [LINES];
  logic [31:0] md [LINES];

  int    n_chk = 0, n_bad = 0;
  string ctx = "base";

  task automatic chk(string tag, string nm, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s act=%h exp=%h", tag, ctx, nm, act, exp);
    end
  endtask

  function automatic int ix(logic [31:0] a); return int'(a[5:2]); endfunction
  function automatic bit m_hit();
    return m_pv && mv[ix(m_pa)] && (mt[ix(m_pa)] == m_pa[31:6]);
  endfunction

  task automatic cyc();
    bit h, e_rsp, acc, seen;
    #1;
    h = m_hit();
    e_rsp = (m_ph == 2 && mw_rdy) || (m_ph == 1 && (h || rf_rdy));
    chk("R2", "cpu_req_ready", 32'(cpu_req_ready), 32'(m_ph == 0));
    chk("R6", "inv_ack", 32'(inv_ack), 32'(m_ack));
    chk("R5", "mem_wr_valid", 32'(mem_wr_valid), 32'(m_ph == 2));
    if (m_ph == 2) begin
      chk("R5", "mem_wr_addr", mem_wr_addr, m_pa);
      chk("R5", "mem_wr_data", mem_wr_data, m_pd);
      chk("R5", "mem_wr_be", 32'(mem_wr_be), 32'(m_pbe));
    end
    chk("R4", "refill_valid", 32'(refill_valid), 32'(m_ph == 1 && !h));
    if (m_ph == 1 && !h) chk("R4", "refill_addr", refill_addr, {m_pa[31:2], 2'b00});
    chk("R10", "cpu_rsp_valid", 32'(cpu_rsp_valid), 32'(e_rsp));
    if (e_rsp) chk("R10", "cpu_rsp_write", 32'(cpu_rsp_write), 32'(m_ph == 2));
    if (e_rsp && m_ph == 1)
      chk("R3", "cpu_rsp_rdata", cpu_rsp_rdata,
          h ? md[ix(m_pa)] : fetch_word({m_pa[31:2], 2'b00}));
    acc  = req_v && cpu_req_ready;
    seen = inv_ack;
    @(posedge clk);
    begin
      int nph = m_ph;
      bit ig;
      case (m_ph)
        0: begin
          ig = inv_r && !m_ack;
          if (req_v) begin
            m_pv = 1; m_pwe = req_we; m_pa = req_a; m_pd = req_d; m_pbe = req_be;
          end
          if (ig) m_ia = int'(inv_a);
          nph = ig ? 3 : (req_v ? (req_we ? 2 : 1) : 0);
        end
        3: begin
          mv[m_ia] = 0;
          nph = m_pv ? (m_pwe ? 2 : 1) : 0;
        end
        2: if (mw_rdy) begin
          if (h) for (int b = 0; b < 4; b++)
            if (m_pbe[b]) md[ix(m_pa)][8*b +: 8] = m_pd[8*b +: 8];
          m_pv = 0; nph = 0;
        end
        default: if (h) begin
          m_pv = 0; nph = 0;
        end else if (rf_rdy) begin
          mv[ix(m_pa)] = 1; mt[ix(m_pa)] = m_pa[31:6];
          md[ix(m_pa)] = fetch_word({m_pa[31:2], 2'b00});
          m_pv = 0; nph = 0;
        end
      endcase
      m_ack = (m_ph == 3);
      m_ph  = nph;
    end
    @(negedge clk);
    if (acc)  req_v = 0;
    if (seen) inv_r = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic put(bit we, logic [31:0] a, logic [31:0] d, logic [3:0] be);
    req_v = 1; req_we = we; req_a = a; req_d = d; req_be = be;
  endtask

  localparam logic [31:0] A_LINE1 = 32'h0000_0044; // tag 1, line 1
  localparam logic [31:0] B_LINE2 = 32'h0000_0048; // tag 1, line 2
  localparam logic [31:0] C_LINE1 = 32'h0000_0084; // tag 2, line 1

  initial begin
    m_ph = 0; m_pv = 0; m_ack = 0; m_ia = 0; m_pwe = 0;
    m_pa = 0; m_pd = 0; m_pbe = 0;
    for (int i = 0; i < LINES; i++) begin mv[i] = 0; mt[i] = '0; md[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    ctx = "R1 reset";
    chk("R1", "ready after reset", 32'(cpu_req_ready), 32'd1);
    chk("R1", "inv_ack after reset", 32'(inv_ack), 32'd0);
    chk("R1", "rsp after reset", 32'(cpu_rsp_valid), 32'd0);
    chk("R1", "mem_wr_valid after reset", 32'(mem_wr_valid), 32'd0);
    @(negedge clk);
    ctx = "R1 first load misses / R4";
    put(0, A_LINE1, 0, 0); run(4);
    ctx = "R3 load hit";
    put(0, A_LINE1, 0, 0); run(3);
    ctx = "R5 store hit bytes";
    put(1, A_LINE1 | 32'h2, 32'hDEAD_BEEF, 4'b0101); run(3);
    put(0, A_LINE1, 0, 0); run(3);
    ctx = "R5 store miss no allocate";
    put(1, C_LINE1, 32'h1234_5678, 4'hF); run(3);
    put(0, A_LINE1, 0, 0); run(3);
    ctx = "R6 lone invalidate";
    inv_r = 1; inv_a = 4'd1; run(4);
    put(0, A_LINE1, 0, 0); run(4);
    ctx = "R7 store collides with invalidate, R8 stalled";
    mw_rdy = 0;
    put(1, A_LINE1, 32'hCAFE_F00D, 4'hF); inv_r = 1; inv_a = 4'd1;
    run(7); mw_rdy = 1; run(3);
    put(0, A_LINE1, 0, 0); run(4);
    ctx = "R7 load collides with invalidate";
    put(0, A_LINE1, 0, 0); inv_r = 1; inv_a = 4'd1; run(5);
    ctx = "R9 invalidate during stalled refill";
    rf_rdy = 0;
    put(0, B_LINE2, 0, 0); run(1);
    inv_r = 1; inv_a = 4'd2; run(5);
    rf_rdy = 1; run(6);
    ctx = "R8 random traffic";
    for (int i = 0; i < 20000; i++) begin
      if (!req_v && ($urandom % 3 == 0))
        put(1'($urandom), {26'($urandom % 2 + 1), 4'($urandom % 4), 2'($urandom)},
            $urandom, 4'($urandom));
      if (!inv_r && ($urandom % 6 == 0)) begin inv_r = 1; inv_a = 4'($urandom % 4); end
      mw_rdy = ($urandom % 3) != 0;
      rf_rdy = ($urandom % 2) != 0;
      cyc();
    end
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4ns * 190000);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule